// File: doc/BRIEF.md
# Tick-Programmable Line Glitch Filter

This block cleans up an asynchronous single-wire bus input, such as a consumer-electronics control line, before protocol logic sees it. The raw line first passes through a two-flop synchronizer. The filtered level changes only when the synchronized line has disagreed with it for a programmed number of filter ticks. Shorter disturbances have no effect on the output.

A prescaler built from the reference clock produces four periodic strobes, spaced a decade apart above the finest one. A 2-bit select chooses which strobe paces the filter. The rejection window is the 3-bit delay times three, counted in selected ticks. The recommended setting is the 1 us tick with a delay of 7, which gives a window of about 21 us. Single-cycle strobes mark each rising and falling change of the filtered level. An enable freezes the filter. A synchronous soft reset forces the output to the bus idle level, which is high.

Top module: `line_glitch_filter`

## Requirements
- R1: The raw input is sampled by two synchronizer flops before the filter sees it. With a delay of 0, an input level present at rising edge E appears on `line_out` after edge E+2, and not after E+1.
- R2: The tick period follows `tick_sel`. Code 0 gives 3 reference cycles (125 ns at 24 MHz). Code 1 gives 24 cycles (1 us). Code 2 gives 240 cycles (10 us). Code 3 gives 2400 cycles (100 us).
- R3: When `delay` is not zero, a new synchronized level is accepted on the (delay×3)-th selected tick during which it differs from `line_out`. If the levels agree again before that tick, the count clears and the disturbance is rejected.
- R4: With `delay` = 0, every synchronized change reaches `line_out` one cycle later, with no tick involved.
- R5: Two conditions force `line_out` high, `rise_stb` low and `fall_stb` low: `rst_n` low (asynchronously) and `soft_rst` high (at each clock while it is held). The prescaler and count are also cleared. The first enabled cycle after the release counts as prescaler phase 0.
- R6: While `en` is low, `line_out` holds its value, no strobe fires, and the prescaler and tick count stay cleared.
- R7: `rise_stb` (or `fall_stb`) is high for exactly the one cycle in which `line_out` is first seen at its new level high (or low). The two strobes are never high together.
- R8: With the recommended setting (code 1, delay 7), a clean level change reaches `line_out` between 20 and 21 us after it reaches the filter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 24 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous reset, held as long as it is high |
| en | input | 1 | Filter and prescaler run while high |
| line_in | input | 1 | Raw asynchronous bus line |
| tick_sel | input | 2 | Tick period code, 0..3 |
| delay | input | 3 | Rejection length in units of three ticks |
| line_out | output | 1 | Filtered line level, idle high |
| rise_stb | output | 1 | One-cycle strobe on a filtered rising change |
| fall_stb | output | 1 | One-cycle strobe on a filtered falling change |

## Verification
With a delay of 0, a change presented before rising edge E shows on `line_out` after edge E+2. This is three cycles counted from the falling edge at which it was driven. The edge strobes appear in that same cycle. With a non-zero delay, the change lands on the tick that completes the count, so its latency falls inside a band of 2 + (3·delay−1)·P to 2 + 3·delay·P cycles, where P is the tick period. The bench drives inputs on falling edges and samples outputs on falling edges. It also steps a behavioural model on every rising edge and compares all three outputs with it each cycle. Directed checks then confirm the exact three-cycle latency, the latency band for each tick code, and the hold behaviour under `en`, `soft_rst` and short pulses.

// File: rtl/line_glitch_filter.sv
module line_glitch_filter #(
  parameter int FINE_DIV = 3,
  parameter int US_DIV   = 24,
  parameter int DECADE   = 10,
  parameter int DLY_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             en,
  input  logic             line_in,
  input  logic [1:0]       tick_sel,
  input  logic [DLY_W-1:0] delay,
  output logic             line_out,
  output logic             rise_stb,
  output logic             fall_stb
);
  localparam int FW = $clog2(FINE_DIV);
  localparam int UW = $clog2(US_DIV);
  localparam int DW = $clog2(DECADE);
  localparam int CW = DLY_W + 2;

  logic [1:0]    sync_q;
  logic [FW-1:0] fine_q;
  logic [UW-1:0] us_q;
  logic [DW-1:0] ten_q, hun_q;
  logic [CW-1:0] cnt_q, thr;
  logic          run, fine_t, us_t, ten_t, hun_t, sel_t, diff;

  assign run    = en && !soft_rst;
  assign fine_t = fine_q == FW'(FINE_DIV - 1);
  assign us_t   = us_q == UW'(US_DIV - 1);
  assign ten_t  = us_t && (ten_q == DW'(DECADE - 1));
  assign hun_t  = ten_t && (hun_q == DW'(DECADE - 1));
  assign thr    = CW'(delay) * CW'(3);
  assign diff   = sync_q[1] ^ line_out;

  always_comb begin
    case (tick_sel)
      2'd0:    sel_t = fine_t;
      2'd1:    sel_t = us_t;
      2'd2:    sel_t = ten_t;
      default: sel_t = hun_t;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], line_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fine_q <= '0; us_q <= '0; ten_q <= '0; hun_q <= '0;
    end else if (!run) begin
      fine_q <= '0; us_q <= '0; ten_q <= '0; hun_q <= '0;
    end else begin
      fine_q <= fine_t ? '0 : fine_q + 1'b1;
      us_q   <= us_t ? '0 : us_q + 1'b1;
      if (us_t)  ten_q <= ten_t ? '0 : ten_q + 1'b1;
      if (ten_t) hun_q <= hun_t ? '0 : hun_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_out <= 1'b1; cnt_q <= '0; rise_stb <= 1'b0; fall_stb <= 1'b0;
    end else if (soft_rst) begin
      line_out <= 1'b1; cnt_q <= '0; rise_stb <= 1'b0; fall_stb <= 1'b0;
    end else begin
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
      if (!en || !diff) begin
        cnt_q <= '0;
      end else if (delay == '0 || (sel_t && cnt_q == thr - 1'b1)) begin
        line_out <= sync_q[1];
        rise_stb <= sync_q[1];
        fall_stb <= !sync_q[1];
        cnt_q    <= '0;
      end else if (sel_t) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_SOFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> line_out && !rise_stb && !fall_stb); // R5
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !soft_rst) |=> $stable(line_out) && !rise_stb && !fall_stb); // R6
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb)); // R7
  AST_RISE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> line_out && !$past(line_out)); // R7
  AST_FALL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> !line_out && $past(line_out)); // R7
  AST_ZERO_DLY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !soft_rst && delay == '0 && diff) |=> line_out == $past(sync_q[1])); // R4
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !diff) |=> $stable(line_out)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (delay != '0) |-> cnt_q < thr || !diff || !en); // R3
endmodule

// File: tb/test_line_glitch_filter.sv
module test_line_glitch_filter;
  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, en = 1'b1, line_in = 1'b1;
  logic [1:0] tick_sel = 2'd0;
  logic [2:0] delay = 3'd0;
  logic line_out, rise_stb, fall_stb;

  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R5";
  bit done = 0;

  line_glitch_filter i_line_glitch_filter (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .en(en), .line_in(line_in),
    .tick_sel(tick_sel), .delay(delay), .line_out(line_out),
    .rise_stb(rise_stb), .fall_stb(fall_stb));

  always #10 clk = ~clk;

  bit m1 = 1, m2 = 1, mo = 1, mr = 0, mf = 0;
  int n = 0, mc = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m1 = 1; m2 = 1; mo = 1; mr = 0; mf = 0; n = 0; mc = 0;
    end else begin
      bit old2, tk;
      old2 = m2; m2 = m1; m1 = line_in;
      mr = 0; mf = 0;
      if (soft_rst) begin
        mo = 1; mc = 0; n = 0;
      end else if (!en) begin
        mc = 0; n = 0;
      end else begin
        case (tick_sel)
          2'd0: tk = (n % 3) == 2;
          2'd1: tk = (n % 24) == 23;
          2'd2: tk = (n % 240) == 239;
          default: tk = (n % 2400) == 2399;
        endcase
        n = n + 1;
        if (old2 == mo) mc = 0;
        else if (delay == 0 || (tk && mc + 1 >= delay * 3)) begin
          mo = old2; mr = old2; mf = !old2; mc = 0;
        end else if (tk) mc = mc + 1;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done)
      check({cur_req, " model"}, {line_out, rise_stb, fall_stb}, {mo, mr, mf});
    if (cycles > 190000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic measure(input bit lvl, output int lat, output int rises, output int falls);
    @(negedge clk);
    line_in = lvl;
    lat = 0; rises = 0; falls = 0;
    while (line_out != lvl && lat < 20000) begin
      @(negedge clk);
      lat++;
      rises += int'(rise_stb);
      falls += int'(fall_stb);
    end
    repeat (3) begin
      @(negedge clk);
      rises += int'(rise_stb);
      falls += int'(fall_stb);
    end
  endtask

  initial begin
    int lat, r, f, per;
    bit lvl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 reset level", line_out, 1);
    check("R5 reset strobes", {rise_stb, fall_stb}, 0);

    cur_req = "R1";
    @(negedge clk); line_in = 0;
    @(negedge clk); @(negedge clk);
    check("R1 not before E+2", line_out, 1);
    @(negedge clk);
    check("R1 after E+2", line_out, 0);
    cur_req = "R4";
    measure(1, lat, r, f);
    check("R4 zero delay latency", lat, 3);
    check("R7 one rise", r, 1);
    measure(0, lat, r, f);
    check("R7 one fall", f, 1);
    check("R7 no rise on fall", r, 0);

    cur_req = "R3";
    tick_sel = 2'd0; delay = 3'd2;
    measure(1, lat, r, f);
    @(negedge clk); line_in = 0;
    repeat (10) @(negedge clk);
    line_in = 1;
    repeat (30) @(negedge clk);
    check("R3 short pulse rejected", line_out, 1);
    measure(0, lat, r, f);
    check_rng("R3 long pulse accepted", lat, 2 + 5 * 3, 3 + 6 * 3);

    cur_req = "R2";
    delay = 3'd1;
    lvl = 0;
    for (int s = 0; s < 4; s++) begin
      tick_sel = 2'(s);
      per = (s == 0) ? 3 : (s == 1) ? 24 : (s == 2) ? 240 : 2400;
      lvl = !lvl;
      measure(lvl, lat, r, f);
      check_rng($sformatf("R2 tick code %0d", s), lat, 2 * per, 3 * per + 4);
    end

    cur_req = "R8";
    tick_sel = 2'd1; delay = 3'd7;
    lvl = !lvl;
    measure(lvl, lat, r, f);
    check_rng("R8 recommended window", lat, 20 * 24, 21 * 24 + 4);

    cur_req = "R6";
    en = 0;
    @(negedge clk); line_in = !lvl;
    repeat (700) @(negedge clk);
    check("R6 held while disabled", line_out, lvl);
    en = 1;
    repeat (600) @(negedge clk);
    check("R6 resumes after enable", line_out, !lvl);

    cur_req = "R5";
    delay = 3'd0;
    measure(0, lat, r, f);
    soft_rst = 1;
    repeat (2) @(negedge clk);
    check("R5 soft reset level", line_out, 1);
    repeat (50) @(negedge clk);
    check("R5 soft reset held", line_out, 1);
    soft_rst = 0;
    repeat (2) @(negedge clk);
    check("R5 release follows line", line_out, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule